// File: doc/BRIEF.md
# Floating-Point Relation and Select Unit

This block relates two IEEE 754 double-precision operands and, in a second mode, picks one of two data operands without a branch, steered by the sign of a third. One operation is accepted per clock. A compare produces a 4-bit one-hot relation code, which appears on a condition output and on a status copy. A compare also records invalid-operation events in sticky flags. Two compare flavours exist. The unordered compare reports only signalling NaNs. The ordered compare also reports any NaN as an invalid comparison.

A select tests operand A against zero. It returns operand B when A is greater than or equal to zero and operand C otherwise. A NaN test always yields C. A select never raises a flag. The sticky flags stay set until an explicit clear. Two summary bits are derived from them: the invalid summary and the enabled-exception summary. A one-cycle interrupt request fires when invalid-operation interrupts are enabled and a flag goes from clear to set.

Operation encoding on `opKind`: 0 = unordered compare, 1 = ordered compare, 2 = select, 3 = no operation. A NaN is an operand with every exponent bit set and a non-zero fraction. It is signalling when fraction bit 51 is 0 and quiet when that bit is 1.

Top module: `fp_relate_unit`

## Requirements
- R1: One clock after an accepted compare (opKind 0 or 1), `relCode` and `relStatus` both hold the same one-hot code, with bit 3 = less, bit 2 = greater, bit 1 = equal and bit 0 = unordered. `resValid` is high exactly one cycle after any accepted opKind 0, 1 or 2.
- R2: For non-NaN operands the code reflects numeric order, including infinities, denormals and mixed signs.
- R3: +0.0 and -0.0 compare equal, in any combination of signs.
- R4: If either compare operand is a NaN, quiet or signalling, the code is unordered (bit 0).
- R5: Either compare flavour sets `flagSnan` when either operand is a signalling NaN.
- R6: The ordered compare sets `flagVc` when either operand is any NaN. The unordered compare never sets `flagVc`.
- R7: A select returns B one clock later when A is greater than or equal to zero, with -0.0 counting as zero. Otherwise it returns C, and a NaN in A always returns C.
- R8: A select changes neither flag, whatever the operands, and leaves `relCode` and `relStatus` unchanged.
- R9: Flags are sticky. `statusClear` clears them at the next edge, but a flag set by an operation in the same cycle stays set.
- R10: `invSummary` is the OR of the two flags. `excSummary` is `invSummary` AND `invIntEn`.
- R11: `irq` pulses for one cycle after an operation that takes a flag from 0 to 1 while `invIntEn` is high. A flag that was already set raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation accepted this edge |
| opKind | input | 2 | 0 unordered cmp, 1 ordered cmp, 2 select, 3 none |
| opA | input | 64 | First compare operand / select test |
| opB | input | 64 | Second compare operand / select value if test >= 0 |
| opC | input | 64 | Select value if test < 0 or NaN |
| statusClear | input | 1 | Clear the sticky flags |
| invIntEn | input | 1 | Invalid-operation interrupt enable |
| relCode | output | 4 | Relation code, condition copy |
| relStatus | output | 4 | Relation code, status copy |
| selResult | output | 64 | Selected data operand |
| resValid | output | 1 | Result of previous operation is present |
| flagSnan | output | 1 | Sticky signalling-NaN invalid flag |
| flagVc | output | 1 | Sticky invalid-compare flag |
| invSummary | output | 1 | OR of invalid flags |
| excSummary | output | 1 | OR of enabled exception flags |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench goes after the signed-zero pair. A design that compares raw bit patterns would call +0 greater than -0, and would steer a -0 select test to C. It mixes quiet and signalling NaNs under both compare flavours. Mixing up the fraction bit that tells them apart, or letting the unordered compare raise the invalid-compare flag, shows up as wrong flags. A select fed signalling NaNs catches any flag leakage from select mode. Repeated invalid events catch a request raised on a flag that was already set, and a clear issued together with a setting operation catches a clear that wins over the set.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  typedef enum logic [1:0] {
    KIND_UCMP = 2'd0,
    KIND_OCMP = 2'd1,
    KIND_SEL  = 2'd2,
    KIND_NONE = 2'd3
  } opKind_e;

  typedef struct packed {
    logic loadRel;
    logic loadSel;
    logic setSnan;
    logic setVc;
    logic clrFlags;
  } strobe_t;

  typedef struct packed {
    logic isNan;
    logic isSnan;
  } nanInfo_t;
endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int W = 1 + EW + FW
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output nanInfo_t     nanA,
  output nanInfo_t     nanB,
  output logic [3:0]   relCode,
  output logic [3:0]   relStatus,
  output logic [W-1:0] selResult
);
  logic [W-1:0] operands [2];
  nanInfo_t     info     [2];

  assign operands[0] = opA;
  assign operands[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_class
    logic expOnes;
    logic fracZero;
    assign expOnes       = &operands[i][W-2:FW];
    assign fracZero      = (operands[i][FW-1:0] == '0);
    assign info[i].isNan = expOnes && !fracZero;
    assign info[i].isSnan = expOnes && !fracZero && !operands[i][FW-1];
  end

  assign nanA = info[0];
  assign nanB = info[1];

  logic [W-2:0] magA, magB;
  logic         signA, signB, bothZero, anyNan;
  logic [3:0]   relNext;

  assign magA     = opA[W-2:0];
  assign magB     = opB[W-2:0];
  assign signA    = opA[W-1];
  assign signB    = opB[W-1];
  assign bothZero = (magA == '0) && (magB == '0);
  assign anyNan   = info[0].isNan || info[1].isNan;

  always_comb begin
    relNext = 4'b0000;
    if (anyNan)                relNext = 4'b0001;
    else if (bothZero)         relNext = 4'b0010;
    else if (signA != signB)   relNext = signA ? 4'b1000 : 4'b0100;
    else if (magA == magB)     relNext = 4'b0010;
    else if ((magA < magB) ^ signA) relNext = 4'b1000;
    else                       relNext = 4'b0100;
  end

  logic testGe;
  assign testGe = !info[0].isNan && (!signA || (magA == '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relCode   <= '0;
      relStatus <= '0;
      selResult <= '0;
    end else begin
      if (strobe.loadRel) begin
        relCode   <= relNext;
        relStatus <= relNext;
      end
      if (strobe.loadSel) selResult <= testGe ? opB : opC;
    end
  end

  assert_rel_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRel |=> ($onehot(relCode) && relStatus == relCode));

  assert_nan_unordered_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRel && anyNan) |=> relCode == 4'b0001);

  assert_zero_equal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRel && bothZero) |=> relCode == 4'b0010);

  assert_sel_keeps_rel_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadSel && !strobe.loadRel) |=> $stable(relCode));
endmodule

// File: rtl/fcs_control.sv
module fcs_control
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opKind,
  input  logic       statusClear,
  input  logic       invIntEn,
  input  nanInfo_t   nanA,
  input  nanInfo_t   nanB,
  output strobe_t    strobe,
  output logic       resValid,
  output logic       flagSnan,
  output logic       flagVc,
  output logic       invSummary,
  output logic       excSummary,
  output logic       irq
);
  opKind_e kind;
  logic    isCmp, isOrd, anySnan, anyNan;

  assign kind    = opKind_e'(opKind);
  assign isCmp   = opValid && (kind == KIND_UCMP || kind == KIND_OCMP);
  assign isOrd   = opValid && (kind == KIND_OCMP);
  assign anySnan = nanA.isSnan || nanB.isSnan;
  assign anyNan  = nanA.isNan || nanB.isNan;

  always_comb begin
    strobe          = '0;
    strobe.loadRel  = isCmp;
    strobe.loadSel  = opValid && (kind == KIND_SEL);
    strobe.setSnan  = isCmp && anySnan;
    strobe.setVc    = isOrd && anyNan;
    strobe.clrFlags = statusClear;
  end

  logic riseSnan, riseVc;
  assign riseSnan = strobe.setSnan && !flagSnan;
  assign riseVc   = strobe.setVc && !flagVc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagSnan <= 1'b0;
      flagVc   <= 1'b0;
      irq      <= 1'b0;
      resValid <= 1'b0;
    end else begin
      flagSnan <= (flagSnan && !strobe.clrFlags) || strobe.setSnan;
      flagVc   <= (flagVc && !strobe.clrFlags) || strobe.setVc;
      irq      <= invIntEn && (riseSnan || riseVc);
      resValid <= strobe.loadRel || strobe.loadSel;
    end
  end

  assign invSummary = flagSnan || flagVc;
  assign excSummary = (flagSnan && invIntEn) || (flagVc && invIntEn);

  assert_sel_no_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 2'd2 && !statusClear) |=> ($stable(flagSnan) && $stable(flagVc)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flagSnan) && !$past(statusClear)) |-> flagSnan);

  assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(invIntEn) && invSummary));

  assert_ucmp_no_vc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 2'd0 && !flagVc) |=> !flagVc);
endmodule

// File: rtl/fp_relate_unit.sv
module fp_relate_unit
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic              statusClear,
  input  logic              invIntEn,
  output logic [3:0]        relCode,
  output logic [3:0]        relStatus,
  output logic [DATA_W-1:0] selResult,
  output logic              resValid,
  output logic              flagSnan,
  output logic              flagVc,
  output logic              invSummary,
  output logic              excSummary,
  output logic              irq
);
  strobe_t  strobe;
  nanInfo_t nanA, nanB;

  fcs_datapath #(.EW(EXP_W), .FW(FRAC_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .opC(opC),
    .nanA(nanA), .nanB(nanB),
    .relCode(relCode), .relStatus(relStatus), .selResult(selResult)
  );

  fcs_control control_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .statusClear(statusClear), .invIntEn(invIntEn),
    .nanA(nanA), .nanB(nanB), .strobe(strobe), .resValid(resValid),
    .flagSnan(flagSnan), .flagVc(flagVc), .invSummary(invSummary),
    .excSummary(excSummary), .irq(irq)
  );

  assert_summary_R10: assert property (@(posedge clk) disable iff (!rstN)
    excSummary |-> (invSummary && invIntEn));
endmodule

// File: tb/fp_relate_unit_tb_top.sv
`timescale 1ns/1ps
module fp_relate_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opKind = 2'd3;
  logic [63:0] opA = '0, opB = '0, opC = '0;
  logic statusClear = 1'b0, invIntEn = 1'b0;
  logic [3:0] relCode, relStatus;
  logic [63:0] selResult;
  logic resValid, flagSnan, flagVc, invSummary, excSummary, irq;

  int total = 0;
  int bad = 0;

  logic [3:0]  mRel = '0;
  logic [63:0] mSel = '0;
  logic mS = 1'b0, mV = 1'b0, mIrq = 1'b0, mValid = 1'b0;

  always #2 clk = ~clk;

  fp_relate_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opA(opA), .opB(opB), .opC(opC), .statusClear(statusClear),
    .invIntEn(invIntEn), .relCode(relCode), .relStatus(relStatus),
    .selResult(selResult), .resValid(resValid), .flagSnan(flagSnan),
    .flagVc(flagVc), .invSummary(invSummary), .excSummary(excSummary), .irq(irq)
  );

  function automatic bit isNanF(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic bit isSnanF(logic [63:0] v);
    return isNanF(v) && (v[51] == 1'b0);
  endfunction

  function automatic longint keyOf(logic [63:0] v);
    longint m;
    m = longint'({1'b0, v[62:0]});
    return v[63] ? -m : m;
  endfunction

  function automatic logic [3:0] refRel(logic [63:0] a, logic [63:0] b);
    if (isNanF(a) || isNanF(b)) return 4'b0001;
    if (keyOf(a) < keyOf(b)) return 4'b1000;
    if (keyOf(a) > keyOf(b)) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic logic [63:0] pickVal(int unsigned sel, logic [63:0] other);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (sel % 10)
      0: return 64'h0000_0000_0000_0000;
      1: return 64'h8000_0000_0000_0000;
      2: return {r[63], 11'h7FF, 52'h0};
      3: return {r[63], 11'h7FF, 1'b1, r[50:0]};
      4: return {r[63], 11'h7FF, 2'b00, r[49:1], 1'b1};
      5: return {r[63], 11'h000, r[51:0]};
      6: return other;
      7: return {~other[63], other[62:0]};
      default: return r;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string ctx);
    chk(relCode == mRel, {ctx, " R1 R2 relCode"}, 64'(relCode), 64'(mRel));
    chk(relStatus == mRel, {ctx, " R1 relStatus"}, 64'(relStatus), 64'(mRel));
    chk(selResult == mSel, {ctx, " R7 selResult"}, selResult, mSel);
    chk(resValid == mValid, {ctx, " R1 resValid"}, 64'(resValid), 64'(mValid));
    chk(flagSnan == mS, {ctx, " R5 flagSnan"}, 64'(flagSnan), 64'(mS));
    chk(flagVc == mV, {ctx, " R6 flagVc"}, 64'(flagVc), 64'(mV));
    chk(invSummary == (mS | mV), {ctx, " R10 invSummary"}, 64'(invSummary), 64'(mS | mV));
    chk(excSummary == ((mS | mV) & invIntEn), {ctx, " R10 excSummary"},
        64'(excSummary), 64'((mS | mV) & invIntEn));
    chk(irq == mIrq, {ctx, " R11 irq"}, 64'(irq), 64'(mIrq));
  endtask

  task automatic doOp(logic [1:0] k, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                      bit clr, bit en, string ctx);
    bit setS, setV;
    opValid = 1'b1; opKind = k; opA = a; opB = b; opC = c;
    statusClear = clr; invIntEn = en;
    setS = (k <= 2'd1) && (isSnanF(a) || isSnanF(b));
    setV = (k == 2'd1) && (isNanF(a) || isNanF(b));
    mIrq = en && ((setS && !mS) || (setV && !mV));
    mS = (mS && !clr) || setS;
    mV = (mV && !clr) || setV;
    if (k <= 2'd1) mRel = refRel(a, b);
    if (k == 2'd2) mSel = (!isNanF(a) && keyOf(a) >= 0) ? b : c;
    mValid = (k != 2'd3);
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; statusClear = 1'b0;
    checkAll(ctx);
  endtask

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0001, SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000, MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] DB = 64'h0000_0000_0000_BEEF, DC = 64'h1234_5678_9ABC_DEF0;

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("reset");
    // R3 signed zeros in compare and select
    doOp(2'd0, PZ, NZ, 0, 0, 1, "R3 +0 vs -0");
    doOp(2'd2, NZ, DB, DC, 0, 1, "R7 -0 test");
    doOp(2'd1, MONE, ONE, 0, 0, 1, "R2 -1 vs 1");
    // R5/R6 unordered with quiet NaN: no flags
    doOp(2'd0, QN, ONE, 0, 0, 1, "R6 ucmp qnan");
    // R8 select with sNaN: no flags, rel kept
    doOp(2'd2, SN, DB, DC, 0, 1, "R8 sel snan");
    // R5/R11 unordered with sNaN sets only snan flag, irq
    doOp(2'd0, ONE, SN, 0, 0, 1, "R5 ucmp snan");
    doOp(2'd0, SN, SN, 0, 0, 1, "R11 already set");
    // R6 ordered with qNaN sets vc
    doOp(2'd1, QN, PZ, 0, 0, 1, "R6 ocmp qnan");
    // R9 clear alone then clear with set
    doOp(2'd3, 0, 0, 0, 1, 1, "R9 clear");
    doOp(2'd1, SN, ONE, 0, 1, 0, "R9 clear with set");
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a, b, c;
      a = pickVal($urandom, 64'h0);
      b = pickVal($urandom, a);
      c = {$urandom, $urandom};
      doOp(2'($urandom % 4), a, b, c, ($urandom % 16) == 0, ($urandom % 3) != 0, "random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule